// File: doc/BRIEF.md
# Divider-Driven Programmable Timer Unit

The unit keeps a free-running internal divider that advances by four on every clock, where one clock stands for one machine step. Software sees the upper byte of that divider as a read-only view and can clear the whole divider by writing to it. An 8-bit timer counter steps forward whenever a divider bit, chosen by the control register, falls from 1 to 0 while the timer is enabled. Because the counter is driven by a falling edge and not by a terminal count, clearing the divider or rewriting the control register can add an extra increment. That behaviour is part of the function.

When the counter wraps from 0xFF, it reads as zero for one step. It then loads the modulo value and raises a one-clock interrupt request. A small state machine sequences this reload. It has three states: Running, Reloading and Reloaded. Its transitions are:
- overflow: from Running or Reloaded into Reloading.
- reload: from Reloading to Reloaded. This loads the modulo value and raises the request.
- cancel: from Reloading to Running, when software writes the counter.
- settle: from Reloaded to Running.

A second falling-edge detector on a high divider bit produces a one-clock tick for an audio sequencer. A double-speed input moves that tick one bit higher.

Top module: `tmr_unit`

## Requirements
- R1: While reset is held, the counter and modulo registers read 0x00. The control register reads 0xF8. The divider view reads 0x00. Both output pulses are low.
- R2: The internal divider is 16 bits wide, grows by 4 each clock and wraps from 65532 to 0. Reading address 0 returns divider bits [15:8].
- R3: Any write to address 0 sets the whole divider to zero on that clock, whatever the data.
- R4: Control bits [1:0] pick the period in divider counts: 0 gives 1024, 1 gives 16, 2 gives 64 and 3 gives 256. Control bit 2 enables the timer. While the timer is disabled, the counter never advances.
- R5: With the timer enabled, the counter (address 1) increments on each clock where the selected divider bit goes from 1 to 0. The selected bit is the period divided by two. The same rule applies when the fall comes from a divider clear.
- R6: A control write (address 3) adds one increment when the old control was enabled with its selected bit at 1, and either the new control is disabled or its selected bit is 0 in the divider value after that clock. Otherwise the write adds nothing.
- R7: On a wrap from 0xFF, the counter reads 0x00 for exactly one clock. On the next clock it takes the modulo value (address 2).
- R8: `timer_irq` is high for exactly the one clock that follows the reload, and at no other time.
- R9: A counter write during the zero clock after a wrap cancels the reload. The written value stays, and no interrupt request follows.
- R10: A modulo write during the zero clock after a wrap is stored, and that same value is loaded into the counter.
- R11: A counter write on the clock just after the reload is ignored. A counter write on the clock after that takes effect.
- R12: `seq_tick` is a one-clock pulse that follows each 1-to-0 fall of divider bit 12. While `double_speed` is high, bit 13 is used instead.
- R13: The modulo register reads back what was written. The control register reads back bits [2:0] as written, with bits [7:3] reading 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine step per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register, combinational |
| double_speed | input | 1 | Moves the sequencer tick to divider bit 13 |
| timer_irq | output | 1 | One-clock interrupt request after a reload |
| seq_tick | output | 1 | One-clock audio sequencer tick |

## Verification
A wrong divider value shows in the counter read within one period of the selected tap. It also shows in the divider view within 64 clocks. A corrupted reload state shows within two clocks: the counter reads a nonzero value in its zero clock, the modulo load goes missing, or the interrupt pulse comes late or twice. A faulty edge detector shows on the clock of the offending divider clear or control write, as one increment too many or too few.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        RL_RUNNING   = 2'd0,
        RL_RELOADING = 2'd1,
        RL_RELOADED  = 2'd2
    } reload_state_e;

    localparam logic [1:0] REG_DIV = 2'd0;
    localparam logic [1:0] REG_CNT = 2'd1;
    localparam logic [1:0] REG_MOD = 2'd2;
    localparam logic [1:0] REG_CTL = 2'd3;

    // Divider bit whose fall advances the counter: half of the selected period.
    function automatic int unsigned period_bit(input logic [1:0] sel);
        return (sel == 2'd0) ? 9 : (2 * int'(sel) + 1);
    endfunction

endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int DIV_W   = 16,
    parameter int STEP    = 4,
    parameter int SEQ_BIT = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             double_speed,
    output logic [DIV_W-1:0] div_q,
    output logic [DIV_W-1:0] div_nxt,
    output logic             seq_tick
);
    localparam int SEQ_DS = SEQ_BIT + 1;

    logic seq_old;
    logic seq_new;

    always_comb begin
        div_nxt = clear ? '0 : div_q + DIV_W'(STEP);
        seq_old = double_speed ? div_q[SEQ_DS]   : div_q[SEQ_BIT];
        seq_new = double_speed ? div_nxt[SEQ_DS] : div_nxt[SEQ_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            seq_tick <= 1'b0;
        end else begin
            div_q    <= div_nxt;
            seq_tick <= seq_old & ~seq_new;
        end
    end

endmodule

// File: rtl/tmr_edge_sel.sv
module tmr_edge_sel #(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] div_cur,
    input  logic [DIV_W-1:0] div_nxt,
    input  logic [2:0]       ctl_cur,
    input  logic [2:0]       ctl_nxt,
    output logic             inc
);
    import tmr_pkg::*;

    localparam int IDX_W = $clog2(DIV_W);

    // Enable gated with the selected divider bit; a fall of this signal is one count.
    function automatic logic tap(input logic [DIV_W-1:0] d, input logic [2:0] c);
        logic [IDX_W-1:0] idx;
        idx = IDX_W'(period_bit(c[1:0]));
        return c[2] & d[idx];
    endfunction

    logic tap_cur;
    logic tap_nxt;

    always_comb begin
        tap_cur = tap(div_cur, ctl_cur);
        tap_nxt = tap(div_nxt, ctl_nxt);
        inc     = tap_cur & ~tap_nxt;
    end

endmodule

// File: rtl/tmr_reload_fsm.sv
module tmr_reload_fsm #(
    parameter int DATA_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc,
    input  logic                   wr_cnt,
    input  logic                   wr_mod,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [DATA_W-1:0]      mod_q,
    output logic [DATA_W-1:0]      cnt_q,
    output tmr_pkg::reload_state_e state_q,
    output logic                   irq_q
);
    import tmr_pkg::*;

    reload_state_e     state_d;
    logic [DATA_W-1:0] cnt_d;
    logic              irq_d;
    logic [DATA_W-1:0] reload_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RL_RUNNING;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            irq_q   <= irq_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        irq_d      = 1'b0;
        reload_val = wr_mod ? wr_data : mod_q;
        unique case (state_q)
            RL_RELOADING: begin
                if (wr_cnt) begin
                    // cancel
                    cnt_d   = wr_data;
                    state_d = RL_RUNNING;
                end else begin
                    // reload
                    cnt_d   = reload_val;
                    irq_d   = 1'b1;
                    state_d = RL_RELOADED;
                end
            end
            RL_RUNNING, RL_RELOADED: begin
                // settle out of Reloaded; software writes lose to the load there
                state_d = RL_RUNNING;
                if (wr_cnt && (state_q == RL_RUNNING)) begin
                    cnt_d = wr_data;
                end else if (inc) begin
                    if (cnt_q == '1) begin
                        // overflow
                        cnt_d   = '0;
                        state_d = RL_RELOADING;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = RL_RUNNING;
        endcase
    end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
    parameter int DIV_W   = 16,
    parameter int DATA_W  = 8,
    parameter int STEP    = 4,
    parameter int SEQ_BIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              double_speed,
    output logic              timer_irq,
    output logic              seq_tick
);
    import tmr_pkg::*;

    localparam int CTL_W = 3;
    localparam int PAD_W = DATA_W - CTL_W;

    logic              wr_div, wr_cnt, wr_mod, wr_ctl;
    logic [DIV_W-1:0]  div_q, div_nxt;
    logic [DATA_W-1:0] mod_q, cnt_q;
    logic [CTL_W-1:0]  ctl_q, ctl_nxt;
    logic              inc;
    reload_state_e     rl_state;

    always_comb begin
        wr_div  = bus_wr && (bus_addr == REG_DIV);
        wr_cnt  = bus_wr && (bus_addr == REG_CNT);
        wr_mod  = bus_wr && (bus_addr == REG_MOD);
        wr_ctl  = bus_wr && (bus_addr == REG_CTL);
        ctl_nxt = wr_ctl ? bus_wdata[CTL_W-1:0] : ctl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
            ctl_q <= '0;
        end else begin
            if (wr_mod) mod_q <= bus_wdata;
            ctl_q <= ctl_nxt;
        end
    end

    tmr_divider #(.DIV_W(DIV_W), .STEP(STEP), .SEQ_BIT(SEQ_BIT)) div_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (wr_div),
        .double_speed (double_speed),
        .div_q        (div_q),
        .div_nxt      (div_nxt),
        .seq_tick     (seq_tick)
    );

    tmr_edge_sel #(.DIV_W(DIV_W)) edge_i (
        .div_cur (div_q),
        .div_nxt (div_nxt),
        .ctl_cur (ctl_q),
        .ctl_nxt (ctl_nxt),
        .inc     (inc)
    );

    tmr_reload_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc),
        .wr_cnt  (wr_cnt),
        .wr_mod  (wr_mod),
        .wr_data (bus_wdata),
        .mod_q   (mod_q),
        .cnt_q   (cnt_q),
        .state_q (rl_state),
        .irq_q   (timer_irq)
    );

    always_comb begin
        unique case (bus_addr)
            REG_DIV: bus_rdata = div_q[DIV_W-1 -: DATA_W];
            REG_CNT: bus_rdata = cnt_q;
            REG_MOD: bus_rdata = mod_q;
            default: bus_rdata = {{PAD_W{1'b1}}, ctl_q};
        endcase
    end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int STEP   = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [1:0]             bus_addr,
    input logic                   bus_wr,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [DIV_W-1:0]       div_q,
    input logic [DATA_W-1:0]      cnt_q,
    input tmr_pkg::reload_state_e state_q,
    input logic                   timer_irq,
    input logic                   seq_tick
);
    import tmr_pkg::*;

    assert_div_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DIV) |=> (div_q == '0));

    assert_div_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == REG_DIV) |=> (div_q == $past(div_q) + DIV_W'(STEP)));

    assert_zero_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RL_RELOADING) |-> (cnt_q == '0));

    assert_irq_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq |-> (state_q == RL_RELOADED));

    assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq |=> !timer_irq);

    assert_cancel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RL_RELOADING && bus_wr && bus_addr == REG_CNT)
        |=> (state_q == RL_RUNNING && !timer_irq));

    assert_seq_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_tick |=> !seq_tick);

    assert_ctl_pad_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_CTL) |-> (bus_rdata[DATA_W-1:3] == '1));

endmodule

bind tmr_unit tmr_unit_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W), .STEP(STEP)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .div_q     (div_q),
    .cnt_q     (cnt_q),
    .state_q   (rl_state),
    .timer_irq (timer_irq),
    .seq_tick  (seq_tick)
);

// File: tb/tmr_unit_tb_top.sv
module tmr_unit_tb_top;
    import tmr_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       double_speed = 1'b0;
    logic       timer_irq;
    logic       seq_tick;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tmr_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .double_speed (double_speed),
        .timer_irq    (timer_irq),
        .seq_tick     (seq_tick)
    );

    // ctl, counter start, clocks after control write, expected counter, expected divider view
    typedef struct packed {
        logic [2:0]  ctl;
        logic [7:0]  init;
        logic [15:0] n;
        logic [7:0]  exp_cnt;
        logic [7:0]  exp_div;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{3'd5, 8'h10, 16'd10,  8'h13, 8'h00},
        '{3'd6, 8'h20, 16'd30,  8'h22, 8'h00},
        '{3'd7, 8'h00, 16'd126, 8'h02, 8'h02},
        '{3'd4, 8'h40, 16'd300, 8'h41, 8'h04},
        '{3'd1, 8'h55, 16'd40,  8'h55, 8'h00},
        '{3'd5, 8'h80, 16'd3,   8'h81, 8'h00},
        '{3'd5, 8'h80, 16'd1,   8'h80, 8'h00},
        '{3'd6, 8'h01, 16'd13,  8'h01, 8'h00},
        '{3'd6, 8'h01, 16'd14,  8'h02, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // After this task the divider holds 8 and the new control is in place.
    task automatic setup(input logic [7:0] mod, input logic [7:0] cnt, input logic [2:0] ctl);
        wr(REG_CTL, 8'h00);
        wr(REG_MOD, mod);
        wr(REG_DIV, 8'hAB);
        wr(REG_CNT, cnt);
        wr(REG_CTL, {5'b0, ctl});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;

        // R1: reset state
        wait_clk(3);
        rd(REG_CNT, v); check("R1 counter", v, 8'h00);
        rd(REG_MOD, v); check("R1 modulo", v, 8'h00);
        rd(REG_CTL, v); check("R1 control", v, 8'hF8);
        rd(REG_DIV, v); check("R1 divider", v, 8'h00);
        check("R1 irq", {7'b0, timer_irq}, 8'h00);
        check("R1 tick", {7'b0, seq_tick}, 8'h00);
        rst_n = 1'b1;
        wait_clk(1);

        // R4/R5: vector table of periods and enables
        for (int i = 0; i < 9; i++) begin
            setup(8'h00, VECS[i].init, VECS[i].ctl);
            wait_clk(int'(VECS[i].n));
            rd(REG_CNT, v); check($sformatf("R4 R5 vec%0d counter", i), v, VECS[i].exp_cnt);
            rd(REG_DIV, v); check($sformatf("R2 vec%0d divider", i), v, VECS[i].exp_div);
        end

        // R2/R3: divider view, clear with arbitrary data, wrap
        wr(REG_CTL, 8'h00);
        wr(REG_DIV, 8'h5C);
        rd(REG_DIV, v); check("R3 clear", v, 8'h00);
        wait_clk(64);
        rd(REG_DIV, v); check("R2 view after 64", v, 8'h01);
        wr(REG_DIV, 8'hFF);
        wait_clk(16383);
        rd(REG_DIV, v); check("R2 top before wrap", v, 8'hFF);
        wait_clk(1);
        rd(REG_DIV, v); check("R2 wrap", v, 8'h00);

        // R5: divider clear with selected bit high gives one count
        setup(8'h00, 8'h30, 3'd5);
        wr(REG_DIV, 8'h00);
        rd(REG_CNT, v); check("R5 clear while bit high", v, 8'h31);
        wait_clk(1);
        wr(REG_DIV, 8'hFF);
        rd(REG_CNT, v); check("R5 clear while bit low", v, 8'h31);

        // R6: control write glitch
        setup(8'h00, 8'h40, 3'd5);
        wr(REG_CTL, 8'h01);
        rd(REG_CNT, v); check("R6 disable glitch", v, 8'h41);
        setup(8'h00, 8'h50, 3'd5);
        wr(REG_CTL, 8'h06);
        rd(REG_CNT, v); check("R6 new bit low glitch", v, 8'h51);
        setup(8'h00, 8'h60, 3'd5);
        wait_clk(8);
        rd(REG_CNT, v); check("R6 counts before switch", v, 8'h62);
        wr(REG_CTL, 8'h06);
        rd(REG_CNT, v); check("R6 new bit high no glitch", v, 8'h62);

        // R7/R8: overflow and reload
        setup(8'hA0, 8'hFF, 3'd5);
        wait_clk(2);
        rd(REG_CNT, v); check("R7 zero window", v, 8'h00);
        check("R8 no irq in zero window", {7'b0, timer_irq}, 8'h00);
        wait_clk(1);
        rd(REG_CNT, v); check("R7 reload value", v, 8'hA0);
        check("R8 irq pulse", {7'b0, timer_irq}, 8'h01);
        wait_clk(1);
        check("R8 irq single", {7'b0, timer_irq}, 8'h00);
        rd(REG_CNT, v); check("R7 value held", v, 8'hA0);

        // R9: cancel
        setup(8'hA0, 8'hFF, 3'd5);
        wait_clk(2);
        wr(REG_CNT, 8'h33);
        rd(REG_CNT, v); check("R9 written value", v, 8'h33);
        check("R9 no irq", {7'b0, timer_irq}, 8'h00);
        wait_clk(1);
        check("R9 no late irq", {7'b0, timer_irq}, 8'h00);
        rd(REG_CNT, v); check("R9 value kept", v, 8'h33);

        // R10: modulo write in zero window
        setup(8'hA0, 8'hFF, 3'd5);
        wait_clk(2);
        wr(REG_MOD, 8'h77);
        rd(REG_CNT, v); check("R10 loaded new modulo", v, 8'h77);
        check("R10 irq", {7'b0, timer_irq}, 8'h01);
        rd(REG_MOD, v); check("R10 modulo stored", v, 8'h77);

        // R11: counter write just after reload
        setup(8'hA0, 8'hFF, 3'd5);
        wait_clk(3);
        wr(REG_CNT, 8'h11);
        rd(REG_CNT, v); check("R11 write ignored", v, 8'hA0);
        wr(REG_CNT, 8'h12);
        rd(REG_CNT, v); check("R11 later write", v, 8'h12);

        // R12: sequencer tick
        wr(REG_CTL, 8'h00);
        double_speed = 1'b0;
        wr(REG_DIV, 8'h00);
        wait_clk(2047);
        check("R12 before bit12 fall", {7'b0, seq_tick}, 8'h00);
        wait_clk(1);
        check("R12 bit12 fall", {7'b0, seq_tick}, 8'h01);
        wait_clk(1);
        check("R12 single pulse", {7'b0, seq_tick}, 8'h00);
        double_speed = 1'b1;
        wr(REG_DIV, 8'h00);
        wait_clk(2048);
        check("R12 double speed ignores bit12", {7'b0, seq_tick}, 8'h00);
        wait_clk(2048);
        check("R12 double speed bit13 fall", {7'b0, seq_tick}, 8'h01);
        double_speed = 1'b0;

        // R13: register readback
        wr(REG_MOD, 8'h5A);
        rd(REG_MOD, v); check("R13 modulo", v, 8'h5A);
        wr(REG_CTL, 8'h02);
        rd(REG_CTL, v); check("R13 control pad", v, 8'hFA);
        wr(REG_CTL, 8'hFF);
        rd(REG_CTL, v); check("R13 control all", v, 8'hFF);

        finish_run();
    end

endmodule